// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs a single DMA channel. Software-side logic arms it with a peripheral start address, a memory start address, a beat count, a configuration word, a feature word and a 3-bit request-line selector. After that, the channel watches the chosen line out of eight peripheral request lines. Each request it accepts is answered with an acknowledge and a one-cycle beat strobe. The strobe starts one single-beat transfer in the external datapath. When the datapath reports that the beat has finished, the channel advances both addresses and decrements its remaining-beat counter.

The acknowledge can be released in two ways. In standard mode it stays high until the request has dropped and the beat has finished. In alternative mode the finished beat alone releases it. The peripheral address step normally follows the peripheral data width. A configuration bit can force that step to 4 bytes. After the final beat has released the acknowledge, the channel raises a one-cycle complete pulse and goes back to idle. Bus mastering, FIFO buffering and arbitration between channels all live outside this block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, ack, beatStrobe and cplIrq are 0, active is 0, and perAddr and memAddr are 0.
- R2: A start pulse in idle with a nonzero beatCount loads perAddr and memAddr from the start inputs on the next edge and sets active. It also latches cfgWord, featWord and reqSel. A start with beatCount 0 is ignored and active stays 0.
- R3: Only request line reqLines[reqSel], as latched at start, can begin a beat. Requests on the other lines have no effect on ack.
- R4: While the channel waits for a request, a high selected line sets ack and a one-cycle beatStrobe on the next clock edge.
- R5: cfgWord bit 9 set makes perAddr step after every finished beat. When the bit is clear, perAddr keeps its value.
- R6: cfgWord bit 10 set makes memAddr step by the peripheral data width after every finished beat. When the bit is clear, memAddr keeps its value.
- R7: cfgWord bits 12:11 encode the peripheral data width: 0 is byte, 1 is halfword, 2 is word, and 3 is treated as word. When cfgWord bit 15 is 0, the peripheral step is 1, 2 or 4 bytes to match the width. When bit 15 is 1, the step is always 4.
- R8: In standard mode (featWord bit 4 = 0), ack stays high after beatDone for as long as the selected request stays high. It drops on the edge after the request is seen low.
- R9: In alternative mode (featWord bit 4 = 1), ack drops on the edge after beatDone even if the request is still high. A request that is still high then starts the next beat one edge later.
- R10: Request changes during a beat in flight or during a held ack start no extra beat. beatDone while no beat is in flight leaves the addresses unchanged.
- R11: When the last beat releases ack, cplIrq is high for exactly one cycle and active returns to 0 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arm the channel with the start values |
| reqSel | input | 3 | Index of the request line to serve |
| cfgWord | input | 32 | Configuration: bit 9 peripheral increment, bit 10 memory increment, bits 12:11 width, bit 15 fixed 4-byte peripheral step |
| featWord | input | 32 | Features: bit 4 selects alternative acknowledge mode |
| perStartAddr | input | 32 | Peripheral start address |
| memStartAddr | input | 32 | Memory start address |
| beatCount | input | 16 | Number of beats to transfer |
| reqLines | input | 8 | Peripheral request lines |
| beatDone | input | 1 | Datapath reports the beat finished |
| ack | output | 1 | Acknowledge to the selected peripheral |
| beatStrobe | output | 1 | One-cycle pulse that starts a beat |
| perAddr | output | 32 | Current peripheral address |
| memAddr | output | 32 | Current memory address |
| cplIrq | output | 1 | One-cycle channel-complete pulse |
| active | output | 1 | Channel armed or transferring |

## Verification
A state machine stuck in the wrong state shows up at ack within one edge. Ack either fails to rise after a selected request or stays high past the release condition of the chosen mode, and the bench checks ack on the first negedge after each stimulus. A wrong step size or a wrong increment enable makes perAddr or memAddr differ from the expected value on the edge right after beatDone. A counter that is off by one moves the cplIrq pulse and the drop of active by one whole beat. Requests applied during a beat that is already in flight would show up as an extra beatStrobe or an extra address step.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CFG_PER_INC   = 9;
  localparam int CFG_MEM_INC   = 10;
  localparam int CFG_WIDTH_LO  = 11;
  localparam int CFG_PER_FIX4  = 15;
  localparam int FEAT_ALT_ACK  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_HOLD = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int SEL_W   = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               countNonZero,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic               altAckIn,
  input  logic [NUM_REQ-1:0] reqLines,
  input  logic               beatDone,
  input  logic               lastBeat,
  input  logic               remZero,
  output seqStrobe_t         strobes,
  output logic               ack,
  output logic               beatStrobe,
  output logic               cplIrq,
  output logic               active
);
  seqState_t state, nextState;
  logic [SEL_W-1:0] selLat;
  logic altLat;
  logic reqHit;
  logic finishing;

  assign reqHit = reqLines[selLat];

  always_comb begin
    nextState    = state;
    strobes.load = 1'b0;
    strobes.step = 1'b0;
    finishing    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && countNonZero) begin
          strobes.load = 1'b1;
          nextState    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (reqHit) nextState = ST_XFER;
      end
      ST_XFER: begin
        if (beatDone) begin
          strobes.step = 1'b1;
          if (altLat || !reqHit) begin
            if (lastBeat) begin
              nextState = ST_IDLE;
              finishing = 1'b1;
            end else begin
              nextState = ST_WAIT;
            end
          end else begin
            nextState = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!reqHit) begin
          if (remZero) begin
            nextState = ST_IDLE;
            finishing = 1'b1;
          end else begin
            nextState = ST_WAIT;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      selLat     <= '0;
      altLat     <= 1'b0;
      beatStrobe <= 1'b0;
      cplIrq     <= 1'b0;
    end else begin
      state      <= nextState;
      beatStrobe <= (state == ST_WAIT) && reqHit;
      cplIrq     <= finishing;
      if (strobes.load) begin
        selLat <= reqSel;
        altLat <= altAckIn;
      end
    end
  end

  assign ack    = (state == ST_XFER) || (state == ST_HOLD);
  assign active = (state != ST_IDLE);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    beatStrobe |=> !beatStrobe);
  assert_strobe_with_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    beatStrobe |-> ack);
  assert_std_ack_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !altLat && reqHit) |=> ack);
  assert_alt_ack_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && beatDone && altLat) |=> !ack);
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    cplIrq |=> !cplIrq);
  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    cplIrq |-> !active);
endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [ADDR_W-1:0] perStartAddr,
  input  logic [ADDR_W-1:0] memStartAddr,
  input  logic [CNT_W-1:0]  beatCount,
  output logic [ADDR_W-1:0] perAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastBeat,
  output logic              remZero
);
  localparam int STEP_W = 3;

  logic [CNT_W-1:0]  remaining;
  logic [STEP_W-1:0] perStep, memStep;
  logic [STEP_W-1:0] unitBytes, perStepNew, memStepNew;

  always_comb begin
    unique case (cfgWord[CFG_WIDTH_LO +: 2])
      2'd0:    unitBytes = STEP_W'(1);
      2'd1:    unitBytes = STEP_W'(2);
      default: unitBytes = STEP_W'(4);
    endcase
    if (!cfgWord[CFG_PER_INC])      perStepNew = '0;
    else if (cfgWord[CFG_PER_FIX4]) perStepNew = STEP_W'(4);
    else                            perStepNew = unitBytes;
    memStepNew = cfgWord[CFG_MEM_INC] ? unitBytes : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perAddr   <= '0;
      memAddr   <= '0;
      remaining <= '0;
      perStep   <= '0;
      memStep   <= '0;
    end else if (strobes.load) begin
      perAddr   <= perStartAddr;
      memAddr   <= memStartAddr;
      remaining <= beatCount;
      perStep   <= perStepNew;
      memStep   <= memStepNew;
    end else if (strobes.step) begin
      perAddr   <= perAddr + ADDR_W'(perStep);
      memAddr   <= memAddr + ADDR_W'(memStep);
      remaining <= remaining - CNT_W'(1);
    end
  end

  assign lastBeat = (remaining == CNT_W'(1));
  assign remZero  = (remaining == '0);

  assert_addr_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> ($stable(perAddr) && $stable(memAddr)));
  assert_step_nonempty_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> !remZero);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int SEL_W   = $clog2(NUM_REQ),
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CFG_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic [CFG_W-1:0]   featWord,
  input  logic [ADDR_W-1:0]  perStartAddr,
  input  logic [ADDR_W-1:0]  memStartAddr,
  input  logic [CNT_W-1:0]   beatCount,
  input  logic [NUM_REQ-1:0] reqLines,
  input  logic               beatDone,
  output logic               ack,
  output logic               beatStrobe,
  output logic [ADDR_W-1:0]  perAddr,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               cplIrq,
  output logic               active
);
  seqStrobe_t strobes;
  logic lastBeat, remZero;

  dma_seq_ctrl #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .countNonZero(beatCount != '0),
    .reqSel(reqSel), .altAckIn(featWord[FEAT_ALT_ACK]), .reqLines(reqLines),
    .beatDone(beatDone), .lastBeat(lastBeat), .remZero(remZero),
    .strobes(strobes), .ack(ack), .beatStrobe(beatStrobe), .cplIrq(cplIrq),
    .active(active)
  );

  dma_seq_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWord(cfgWord),
    .perStartAddr(perStartAddr), .memStartAddr(memStartAddr),
    .beatCount(beatCount), .perAddr(perAddr), .memAddr(memAddr),
    .lastBeat(lastBeat), .remZero(remZero)
  );
endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] reqSel = '0;
  logic [31:0] cfgWord = '0, featWord = '0;
  logic [31:0] perStartAddr = '0, memStartAddr = '0;
  logic [15:0] beatCount = '0;
  logic [7:0] reqLines = '0;
  logic beatDone = 1'b0;
  logic ack, beatStrobe, cplIrq, active;
  logic [31:0] perAddr, memAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rstN(rstN), .start(start), .reqSel(reqSel), .cfgWord(cfgWord),
    .featWord(featWord), .perStartAddr(perStartAddr), .memStartAddr(memStartAddr),
    .beatCount(beatCount), .reqLines(reqLines), .beatDone(beatDone),
    .ack(ack), .beatStrobe(beatStrobe), .perAddr(perAddr), .memAddr(memAddr),
    .cplIrq(cplIrq), .active(active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] pa, input logic [31:0] ma, input logic [15:0] cnt,
                     input logic [31:0] cfg, input logic [31:0] feat, input logic [2:0] sel);
    perStartAddr = pa; memStartAddr = ma; beatCount = cnt;
    cfgWord = cfg; featWord = feat; reqSel = sel; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic testReset();
    check("R1 ack", ack, 0);
    check("R1 beatStrobe", beatStrobe, 0);
    check("R1 cplIrq", cplIrq, 0);
    check("R1 active", active, 0);
    check("R1 perAddr", perAddr, 0);
    check("R1 memAddr", memAddr, 0);
  endtask

  // Standard mode, halfword width, both increments, line 3, two beats
  task automatic testStandard();
    arm(32'h1000, 32'h8000, 16'd2, 32'h0000_0E00, 32'h0, 3'd3);
    check("R2 active", active, 1);
    check("R2 perAddr load", perAddr, 32'h1000);
    check("R2 memAddr load", memAddr, 32'h8000);
    reqLines = 8'h20;
    tick(); tick();
    check("R3 other line ignored", ack, 0);
    reqLines = 8'h08;
    tick();
    check("R4 ack", ack, 1);
    check("R4 strobe", beatStrobe, 1);
    tick();
    check("R4 strobe one cycle", beatStrobe, 0);
    beatDone = 1'b1;
    tick();
    beatDone = 1'b0;
    check("R8 ack held", ack, 1);
    check("R5 perAddr step", perAddr, 32'h1002);
    check("R6 memAddr step", memAddr, 32'h8002);
    tick();
    check("R8 ack still held", ack, 1);
    check("R10 no strobe while held", beatStrobe, 0);
    reqLines = 8'h00;
    tick();
    check("R8 ack released", ack, 0);
    check("R11 no early irq", cplIrq, 0);
    reqLines = 8'h08;
    tick();
    check("R4 second ack", ack, 1);
    reqLines = 8'h00; tick();
    reqLines = 8'h08; tick();
    check("R10 no restart in flight", beatStrobe, 0);
    reqLines = 8'h00; beatDone = 1'b1;
    tick();
    beatDone = 1'b0;
    check("R11 irq", cplIrq, 1);
    check("R11 idle", active, 0);
    check("R10 single step", perAddr, 32'h1004);
    tick();
    check("R11 irq one cycle", cplIrq, 0);
  endtask

  // Alternative mode, byte width, fixed 4-byte peripheral step, no mem increment
  task automatic testAlt();
    arm(32'h2000, 32'h9000, 16'd2, 32'h0000_8200, 32'h10, 3'd6);
    reqLines = 8'h40;
    tick();
    check("R4 ack alt", ack, 1);
    beatDone = 1'b1;
    tick();
    beatDone = 1'b0;
    check("R9 ack drops", ack, 0);
    check("R7 fixed step", perAddr, 32'h2004);
    check("R6 mem held", memAddr, 32'h9000);
    tick();
    check("R9 next beat ack", ack, 1);
    check("R9 next beat strobe", beatStrobe, 1);
    beatDone = 1'b1;
    tick();
    beatDone = 1'b0;
    check("R9 final drop", ack, 0);
    check("R11 irq alt", cplIrq, 1);
    check("R7 fixed step 2", perAddr, 32'h2008);
    reqLines = 8'h00;
    tick();
  endtask

  // Word width peripheral step, no increments, ignored inputs
  task automatic testWidths();
    arm(32'h10, 32'h20, 16'd0, 32'h0000_1200, 32'h0, 3'd0);
    check("R2 zero count ignored", active, 0);
    arm(32'h100, 32'h200, 16'd1, 32'h0000_1200, 32'h0, 3'd1);
    beatDone = 1'b1;
    tick();
    beatDone = 1'b0;
    check("R10 stray done per", perAddr, 32'h100);
    check("R10 stray done mem", memAddr, 32'h200);
    reqLines = 8'h02;
    tick();
    beatDone = 1'b1; reqLines = 8'h00;
    tick();
    beatDone = 1'b0;
    check("R7 word step", perAddr, 32'h104);
    check("R6 mem held off", memAddr, 32'h200);
    check("R11 irq single beat", cplIrq, 1);
    arm(32'h300, 32'h400, 16'd1, 32'h0000_0000, 32'h0, 3'd2);
    reqLines = 8'h04;
    tick();
    beatDone = 1'b1; reqLines = 8'h00;
    tick();
    beatDone = 1'b0;
    check("R5 per held off", perAddr, 32'h300);
    check("R6 mem held off 2", memAddr, 32'h400);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testStandard();
    testAlt();
    testWidths();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule